// File: doc/BRIEF.md
# Triggered PWM Burst Time Base

This block is the time base of one PWM generator that runs in bursts. A start event begins a burst, and the burst then runs a programmed number of PWM cycles, from one to eight. Each PWM cycle is a counter that goes from zero up to a period value. The output is high for a window that a phase value and a duty value place inside that count. A one-clock end-of-cycle pulse marks the end of each PWM cycle.

The start event can come from one of three kinds of source. The generator's own end of cycle makes it run without stopping. The trigger line of one of up to eight peer generators can start it. A third setting selects no hardware source, so that only a software trigger can start a burst. A sync input can be ORed with any of these sources. A trigger that arrives during a burst is either ignored (single-trigger mode) or reloads the remaining cycle count (retriggerable mode).

A 32-bit control word holds the settings. It is written through a single write strobe. The period, duty and phase can each be taken from the local registers or from the shared master registers. While the generator is enabled, the burst length, trigger mode and source fields are locked.

Top module: `pwm_trig_seq`

## Requirements
- R1: After reset the control word is zero, so the generator is disabled, and `busy`, `pwm_out` and `eoc_pulse` are all low.
- R2: While busy, the counter starts at 0 and steps once per clock. `eoc_pulse` is high for one clock when the count reaches or exceeds the selected period, and the count then returns to 0, so a cycle lasts period+1 clocks. `pwm_out` is high when phase <= count < phase+duty. Both outputs are low while the generator is not busy.
- R3: A start event accepted while the generator is idle sets `busy` on the next clock with the count at 0. The burst then runs N+1 PWM cycles, where N is the burst field `ctl_wdata[10:8]`. `busy` falls after the last end-of-cycle pulse.
- R4: When the mode field `[23:22]` is 00, a start event during a burst is ignored, except in the final end-of-cycle clock. The reserved codes 10 and 11 behave the same way.
- R5: When the mode field is 01, a start event during a burst (outside the final end-of-cycle clock) reloads the remaining count. The current cycle finishes, and N further cycles follow.
- R6: Source field `[19:16]` = 0000 makes the generator start itself whenever it is idle and at every final end of cycle, so it runs continuously while enabled.
- R7: Source codes 0001 to 1000 select `peer_trig[0]` to `peer_trig[7]` as the hardware start event. The other peer lines have no effect.
- R8: Source 1111 selects no hardware trigger, and the reserved codes 1001 to 1110 act like 1111. In that case only `sw_trig`, or sync when enabled, can start a burst.
- R9: With `sync_en` high, `sync_in` is ORed with the selected start event. With `sync_en` low, `sync_in` has no effect.
- R10: Bit 31 selects the master duty, bit 30 the master period and bit 29 the master phase. A 0 in any of these bits selects the local value. These bits can be written at any time.
- R11: With enable bit 15 low the generator stays idle. Clearing the bit during a burst makes `busy` low on the next clock.
- R12: A write while the generator is enabled changes only the enable bit and the three select bits. The burst, mode and source fields keep their old values.
- R13: A start event present in the final end-of-cycle clock of a burst starts a new burst at once, so `busy` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| loc_period | input | CW | Local period value |
| loc_duty | input | CW | Local duty value |
| loc_phase | input | CW | Local phase value |
| mst_period | input | CW | Master period value |
| mst_duty | input | CW | Master duty value |
| mst_phase | input | CW | Master phase value |
| peer_trig | input | NPEER | Trigger lines from peer generators |
| sw_trig | input | 1 | Software trigger pulse |
| sync_in | input | 1 | Sync input |
| sync_en | input | 1 | Enables ORing of sync with the selected source |
| pwm_out | output | 1 | PWM output |
| eoc_pulse | output | 1 | One-clock end-of-cycle pulse |
| busy | output | 1 | High while a burst runs |

## Verification
A wrong remaining-cycle count shows at the ports as a wrong number of `eoc_pulse` events before `busy` falls. This becomes visible only at the end of a burst, which can be up to eight periods after the fault. A corrupted counter or a wrong register selection shifts `pwm_out` or `eoc_pulse` within the same PWM cycle. A write that slips through the field lock is seen only at the next burst, as a changed length or a changed start source. For this reason the bench compares all three outputs every clock against a model built from the requirements, and it also counts pulses per burst.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;

    localparam int BIT_DUTY_M = 31;
    localparam int BIT_PER_M  = 30;
    localparam int BIT_PH_M   = 29;
    localparam int BIT_EN     = 15;
    localparam int LSB_MODE   = 22;
    localparam int LSB_SRC    = 16;
    localparam int LSB_BURST  = 8;

    localparam logic [3:0] SRC_SELF = 4'd0;
    localparam logic [1:0] MODE_RETRIG = 2'b01;

    typedef struct packed {
        logic       duty_m;
        logic       per_m;
        logic       ph_m;
        logic       en;
        logic [1:0] mode;
        logic [3:0] src;
        logic [2:0] nburst;
    } ctl_t;

    function automatic ctl_t unpack_ctl(input logic [31:0] w);
        ctl_t c;
        c.duty_m = w[BIT_DUTY_M];
        c.per_m  = w[BIT_PER_M];
        c.ph_m   = w[BIT_PH_M];
        c.en     = w[BIT_EN];
        c.mode   = w[LSB_MODE +: 2];
        c.src    = w[LSB_SRC +: 4];
        c.nburst = w[LSB_BURST +: 3];
        return c;
    endfunction

endpackage

// File: rtl/pwm_ctl_reg.sv
module pwm_ctl_reg
    import pwm_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [31:0] wdata,
    output ctl_t        ctl
);

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_t w;
        w     = unpack_ctl(wdata);
        ctl_d = ctl_q;
        if (wr) begin
            if (ctl_q.en) begin
                ctl_d.en     = w.en;
                ctl_d.duty_m = w.duty_m;
                ctl_d.per_m  = w.per_m;
                ctl_d.ph_m   = w.ph_m;
            end else begin
                ctl_d = w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl = ctl_q;

    assert_locked_fields_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.en && wr) |=> ($stable(ctl_q.nburst) && $stable(ctl_q.mode) && $stable(ctl_q.src)));

endmodule

// File: rtl/pwm_trig_sel.sv
module pwm_trig_sel
    import pwm_seq_pkg::*;
#(
    parameter int NPEER = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       src,
    input  logic [NPEER-1:0] peer_trig,
    input  logic             sw_trig,
    input  logic             sync_in,
    input  logic             sync_en,
    input  logic             eoc,
    input  logic             busy,
    output logic             start
);

    logic [NPEER-1:0] hit;

    for (genvar k = 0; k < NPEER; k++) begin : g_peer
        assign hit[k] = (src == 4'(k + 1)) && peer_trig[k];
    end

    logic self_t;
    assign self_t = (src == SRC_SELF) && (eoc || !busy);
    assign start  = (|hit) || self_t || sw_trig || (sync_en && sync_in);

    assert_no_hw_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((src > 4'(NPEER)) && !sw_trig && !(sync_en && sync_in)) |-> !start);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_seq_pkg::*;
#(
    parameter int CW = 16,
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          retrig,
    input  logic [BW-1:0] nburst,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] duty,
    input  logic [CW-1:0] phase,
    input  logic          start,
    output logic          eoc,
    output logic          last_eoc,
    output logic          pwm,
    output logic          busy
);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [BW-1:0] rem;
    } tb_state_t;

    tb_state_t s_d, s_q;
    logic      accept;
    logic [CW:0] win_end;

    assign eoc      = s_q.busy && (s_q.cnt >= period);
    assign last_eoc = eoc && (s_q.rem == '0);
    assign accept   = !s_q.busy || last_eoc;
    assign win_end  = {1'b0, phase} + {1'b0, duty};
    assign pwm      = s_q.busy && (s_q.cnt >= phase) && ({1'b0, s_q.cnt} < win_end);
    assign busy     = s_q.busy;

    always_comb begin
        s_d = s_q;
        if (!en) begin
            s_d = '0;
        end else if (start && accept) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
            s_d.rem  = nburst;
        end else if (s_q.busy) begin
            s_d.cnt = eoc ? '0 : s_q.cnt + 1'b1;
            if (last_eoc) begin
                s_d.busy = 1'b0;
            end else if (start && retrig) begin
                s_d.rem = nburst;
            end else if (eoc) begin
                s_d.rem = s_q.rem - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);

    assert_burst_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !s_q.busy && start) |=> (busy && s_q.cnt == '0 && s_q.rem == $past(nburst)));

    assert_single_ignores_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s_q.busy && !eoc && !retrig) |=> (s_q.rem == $past(s_q.rem)));

    assert_cycle_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && eoc && !last_eoc) |=> (busy && s_q.cnt == '0));

endmodule

// File: rtl/pwm_trig_seq.sv
module pwm_trig_seq
    import pwm_seq_pkg::*;
#(
    parameter int CW    = 16,
    parameter int NPEER = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [31:0]      ctl_wdata,
    input  logic [CW-1:0]    loc_period,
    input  logic [CW-1:0]    loc_duty,
    input  logic [CW-1:0]    loc_phase,
    input  logic [CW-1:0]    mst_period,
    input  logic [CW-1:0]    mst_duty,
    input  logic [CW-1:0]    mst_phase,
    input  logic [NPEER-1:0] peer_trig,
    input  logic             sw_trig,
    input  logic             sync_in,
    input  logic             sync_en,
    output logic             pwm_out,
    output logic             eoc_pulse,
    output logic             busy
);

    localparam int BW = 3;

    ctl_t          ctl;
    logic [CW-1:0] sel_per, sel_duty, sel_ph;
    logic          start, eoc, last_eoc, busy_i;

    pwm_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctl_wr),
        .wdata (ctl_wdata),
        .ctl   (ctl)
    );

    assign sel_per  = ctl.per_m  ? mst_period : loc_period;
    assign sel_duty = ctl.duty_m ? mst_duty   : loc_duty;
    assign sel_ph   = ctl.ph_m   ? mst_phase  : loc_phase;

    pwm_trig_sel #(.NPEER(NPEER)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (ctl.src),
        .peer_trig (peer_trig),
        .sw_trig   (sw_trig),
        .sync_in   (sync_in),
        .sync_en   (sync_en),
        .eoc       (eoc),
        .busy      (busy_i),
        .start     (start)
    );

    pwm_timebase #(.CW(CW), .BW(BW)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctl.en),
        .retrig   (ctl.mode == MODE_RETRIG),
        .nburst   (ctl.nburst),
        .period   (sel_per),
        .duty     (sel_duty),
        .phase    (sel_ph),
        .start    (start),
        .eoc      (eoc),
        .last_eoc (last_eoc),
        .pwm      (pwm_out),
        .busy     (busy_i)
    );

    assign eoc_pulse = eoc;
    assign busy      = busy_i;

    assert_restart_on_last_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.en && last_eoc && start) |=> busy);

endmodule

// File: tb/sim_pwm_trig_seq.sv
module sim_pwm_trig_seq;

    localparam int CW = 16;
    localparam logic [31:0] KEEP = 32'hE0CF_8700;
    localparam logic [31:0] LOCK = 32'h00CF_0700;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [CW-1:0] loc_period = 16'd3, loc_duty = 16'd2, loc_phase = 16'd1;
    logic [CW-1:0] mst_period = 16'd5, mst_duty = 16'd3, mst_phase = 16'd0;
    logic [7:0] peer_trig = '0;
    logic sw_trig = 1'b0, sync_in = 1'b0, sync_en = 1'b0;
    logic pwm_out, eoc_pulse, busy;

    always #4 clk = ~clk;

    pwm_trig_seq u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .loc_period(loc_period), .loc_duty(loc_duty), .loc_phase(loc_phase),
        .mst_period(mst_period), .mst_duty(mst_duty), .mst_phase(mst_phase),
        .peer_trig(peer_trig), .sw_trig(sw_trig), .sync_in(sync_in), .sync_en(sync_en),
        .pwm_out(pwm_out), .eoc_pulse(eoc_pulse), .busy(busy)
    );

    int total = 0, bad = 0, eoc_seen = 0, cycles = 0;
    string cur_req = "R1";

    logic [31:0] m_ctl = '0;
    logic        m_busy = 1'b0;
    logic [15:0] m_cnt = '0;
    logic [2:0]  m_rem = '0;

    function automatic logic [15:0] f_per(); return m_ctl[30] ? mst_period : loc_period; endfunction
    function automatic logic [15:0] f_duty(); return m_ctl[31] ? mst_duty : loc_duty; endfunction
    function automatic logic [15:0] f_ph(); return m_ctl[29] ? mst_phase : loc_phase; endfunction
    function automatic logic f_eoc(); return m_busy && (m_cnt >= f_per()); endfunction
    function automatic logic f_pwm();
        return m_busy && (m_cnt >= f_ph()) && ({1'b0, m_cnt} < ({1'b0, f_ph()} + {1'b0, f_duty()}));
    endfunction
    function automatic logic f_start();
        logic [3:0] s;
        logic hw;
        s  = m_ctl[19:16];
        hw = 1'b0;
        if (s == 4'd0) hw = f_eoc() || !m_busy;
        else if (s <= 4'd8) hw = peer_trig[s - 4'd1];
        return hw || sw_trig || (sync_en && sync_in);
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic e, last, st;
        logic [31:0] c_next;
        e    = f_eoc();
        last = e && (m_rem == 3'd0);
        st   = f_start();
        c_next = m_ctl;
        if (ctl_wr) c_next = m_ctl[15] ? ((m_ctl & LOCK) | (ctl_wdata & KEEP & ~LOCK)) : (ctl_wdata & KEEP);
        if (!m_ctl[15]) begin
            m_busy = 1'b0; m_cnt = '0; m_rem = '0;
        end else if (st && (!m_busy || last)) begin
            m_busy = 1'b1; m_cnt = '0; m_rem = m_ctl[10:8];
        end else if (m_busy) begin
            m_cnt = e ? 16'd0 : m_cnt + 16'd1;
            if (last) m_busy = 1'b0;
            else if (st && m_ctl[23:22] == 2'b01) m_rem = m_ctl[10:8];
            else if (e) m_rem = m_rem - 3'd1;
        end
        m_ctl = c_next;
    endtask

    task automatic step();
        #1;
        chk({pwm_out, eoc_pulse, busy} === {f_pwm(), f_eoc(), m_busy}, cur_req,
            {pwm_out, eoc_pulse, busy}, {f_pwm(), f_eoc(), m_busy});
        if (eoc_pulse) eoc_seen++;
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr_ctl(input logic [31:0] v);
        ctl_wr = 1'b1; ctl_wdata = v; step(); ctl_wr = 1'b0;
    endtask

    task automatic pulse_sw();
        sw_trig = 1'b1; step(); sw_trig = 1'b0;
    endtask

    function automatic logic [31:0] mk(input logic en, input logic [1:0] mode,
                                       input logic [3:0] src, input logic [2:0] n);
        return {3'b000, 5'd0, mode, 2'b00, src, en, 4'd0, n, 8'd0};
    endfunction

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                bad++; total++;
                $display("FAIL watchdog expired");
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : main
        int n0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        chk(!busy && !pwm_out && !eoc_pulse, "R1", {pwm_out, eoc_pulse, busy}, 0);
        run(2);

        cur_req = "R2";
        loc_period = 16'd5; loc_duty = 16'd2; loc_phase = 16'd1;
        wr_ctl(mk(1'b1, 2'b00, 4'hF, 3'd0));
        pulse_sw(); run(9);

        cur_req = "R3";
        loc_period = 16'd3;
        wr_ctl(0); wr_ctl(mk(1'b1, 2'b00, 4'hF, 3'd3));
        n0 = eoc_seen; pulse_sw(); run(24);
        chk(eoc_seen - n0 == 4, "R3", eoc_seen - n0, 4);

        foreach (cur_req[i]) ;
        for (int m = 0; m < 2; m++) begin
            cur_req = "R4";
            wr_ctl(0); wr_ctl(mk(1'b1, m ? 2'b10 : 2'b00, 4'hF, 3'd1));
            n0 = eoc_seen; pulse_sw(); run(5); pulse_sw(); run(12);
            chk(eoc_seen - n0 == 2, "R4", eoc_seen - n0, 2);
        end

        cur_req = "R5";
        wr_ctl(0); wr_ctl(mk(1'b1, 2'b01, 4'hF, 3'd1));
        n0 = eoc_seen; pulse_sw(); run(5); pulse_sw(); run(14);
        chk(eoc_seen - n0 == 3, "R5", eoc_seen - n0, 3);

        cur_req = "R6";
        wr_ctl(0); wr_ctl(mk(1'b1, 2'b00, 4'h0, 3'd0));
        run(30);
        chk(busy == 1'b1, "R6", busy, 1);

        cur_req = "R7";
        wr_ctl(0); wr_ctl(mk(1'b1, 2'b00, 4'h3, 3'd0));
        peer_trig = 8'b1111_1011; step(); peer_trig = '0;
        chk(busy == 1'b0, "R7", busy, 0);
        peer_trig = 8'b0000_0100; step(); peer_trig = '0;
        chk(busy == 1'b1, "R7", busy, 1);
        run(6);

        cur_req = "R8";
        for (int s = 9; s < 16; s += 6) begin
            wr_ctl(0); wr_ctl(mk(1'b1, 2'b00, 4'(s), 3'd0));
            peer_trig = 8'hFF; step(); peer_trig = '0;
            chk(busy == 1'b0, "R8", busy, 0);
            pulse_sw(); chk(busy == 1'b1, "R8", busy, 1); run(6);
        end

        cur_req = "R9";
        sync_en = 1'b0; sync_in = 1'b1; step(); sync_in = 1'b0;
        chk(busy == 1'b0, "R9", busy, 0);
        sync_en = 1'b1; sync_in = 1'b1; step(); sync_in = 1'b0; sync_en = 1'b0;
        chk(busy == 1'b1, "R9", busy, 1);
        run(6);

        cur_req = "R10";
        wr_ctl(mk(1'b1, 2'b00, 4'h0, 3'd0));
        run(5);
        wr_ctl(32'hE000_0000 | mk(1'b1, 2'b00, 4'h0, 3'd0));
        run(14);
        wr_ctl(32'h4000_0000 | mk(1'b1, 2'b00, 4'h0, 3'd0));
        run(10);

        cur_req = "R11";
        wr_ctl(0); run(2);
        chk(busy == 1'b0, "R11", busy, 0);
        pulse_sw(); chk(busy == 1'b0, "R11", busy, 0);

        cur_req = "R12";
        wr_ctl(mk(1'b1, 2'b00, 4'hF, 3'd1));
        wr_ctl(mk(1'b1, 2'b01, 4'h0, 3'd6));
        run(3);
        chk(busy == 1'b0, "R12", busy, 0);
        n0 = eoc_seen; pulse_sw(); run(12);
        chk(eoc_seen - n0 == 2, "R12", eoc_seen - n0, 2);

        cur_req = "R13";
        wr_ctl(0); wr_ctl(mk(1'b1, 2'b00, 4'hF, 3'd0));
        pulse_sw(); run(3);
        pulse_sw();
        chk(busy == 1'b1, "R13", busy, 1);
        run(6);

        cur_req = "R3";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 40) == 0) begin
                ctl_wr = 1'b1;
                ctl_wdata = $urandom;
            end
            if ($urandom_range(0, 200) == 0) begin
                loc_period = 16'($urandom_range(0, 6)); loc_duty = 16'($urandom_range(0, 7));
                loc_phase  = 16'($urandom_range(0, 5)); mst_period = 16'($urandom_range(0, 6));
                mst_duty   = 16'($urandom_range(0, 7)); mst_phase  = 16'($urandom_range(0, 5));
            end
            peer_trig = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'h00;
            sw_trig   = ($urandom_range(0, 15) == 0);
            sync_en   = $urandom_range(0, 1);
            sync_in   = ($urandom_range(0, 15) == 0);
            step();
            ctl_wr = 1'b0;
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial process::self().srandom(32'd2024);

endmodule